// File: doc/BRIEF.md
# Mixed-Signal General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port. Each pin can be set on its own to one of three modes: a push-pull output, a digital input, or an analog input. Three registers control the port. A data latch holds the output values. A direction register sets output or input for each pin. An input-enable register chooses digital or analog for each pin whose direction bit is 0. When a pin is analog, its digital input path is gated off so that the pin does not disturb the analog function sharing it. The port also raises a per-pin analog-select line for that function.

Software uses a small synchronous register bus, made of an offset, a write strobe, write data and combinational read data. The data register is at offset 0, the direction register at offset 1 and the input-enable register at offset 2. Reading offset 0 returns a value chosen per bit by that bit's mode: the latch for an output pin, the synchronized pad level for a digital input, and zero for an analog pin. To move a pin into analog mode without glitching, software clears its direction bit first and its input-enable bit after that.

Top module: `mio_port`

## Requirements
- R1: After reset the data latch reads 0x00, the direction register reads 0x00 and the input-enable register reads 0xFF. Every pin is then a digital input, with pad_oe = 0x00 and ana_sel = 0x00.
- R2: A pin whose direction bit is 1 has pad_oe = 1, whatever its input-enable bit holds. pad_out always carries the data latch, bit for bit.
- R3: For a pin whose direction bit is 1, reading offset 0 returns that pin's latch bit and not the pad level.
- R4: For a pin with direction 0 and input-enable 1, pad_oe is 0 and reading offset 0 returns the synchronized pad level.
- R5: For a pin with direction 0 and input-enable 0 (analog), pad_oe is 0 and reading offset 0 returns 0 for that bit.
- R6: Offset 0 writes the data latch, offset 1 the direction register and offset 2 the input-enable register. A write takes effect at the next rising clock edge. Offsets 1 and 2 read back the register contents, and reads are combinational.
- R7: A write to offset 0 updates the latch in every mode, so a value preloaded while a pin is analog or input appears on pad_out and on reads once the pin is switched to output.
- R8: A change on pad_in shows up in an offset-0 read of a digital-input pin after exactly two rising clock edges.
- R9: Offset 3 is unmapped. It reads as 0x00, and a write to it changes no register and no pad output.
- R10: ana_sel for each pin is 1 exactly when both its direction bit and its input-enable bit are 0. ana_sel and pad_oe are never both 1 on the same pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_in | input | 8 | Raw pad levels |
| ana_sel | output | 8 | Per-pin analog-select |

## Verification
A corrupted direction or input-enable bit shows up at once on pad_oe or ana_sel, and in the same cycle in the offset-0 read, which switches between latch, pad and zero. A wrong latch bit shows directly on pad_out. A fault in the synchronizer shows only in offset-0 reads of input pins, either one edge early or one edge late, which is why the bench samples that read at both edge counts. A decode fault that lets an unmapped write through shows one edge later, when the registers are read back.

// File: rtl/mio_pkg.sv
package mio_pkg;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_DIR  = 1;
  localparam int unsigned OFS_IEN  = 2;

  typedef enum logic [1:0] {
    PIN_ANALOG = 2'd0,
    PIN_INPUT  = 2'd1,
    PIN_OUTPUT = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e pin_mode(input logic dir, input logic ien);
    if (dir)      return PIN_OUTPUT;
    else if (ien) return PIN_INPUT;
    else          return PIN_ANALOG;
  endfunction

  function automatic logic pin_read(input pin_mode_e m, input logic latch, input logic pin);
    case (m)
      PIN_OUTPUT: return latch;
      PIN_INPUT:  return pin;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mio_regs.sv
module mio_regs #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic              wr_data,
  output logic              wr_dir,
  output logic              wr_ien,
  output logic              wr_unmapped
);
  import mio_pkg::*;

  always_comb begin
    wr_data     = bus_we && (bus_addr == ADDR_W'(OFS_DATA));
    wr_dir      = bus_we && (bus_addr == ADDR_W'(OFS_DIR));
    wr_ien      = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
    wr_unmapped = bus_we && !(wr_data || wr_dir || wr_ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '1;
    end else begin
      if (wr_data) data_q <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata;
    end
  end

  // R6: each write lands at the following edge
  p_data_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(bus_wdata));
  p_dir_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(bus_wdata));
  p_ien_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> ien_q == $past(bus_wdata));
  // R9: unmapped writes leave all state alone
  p_unmapped_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(data_q) && $stable(dir_q) && $stable(ien_q)));

endmodule

// File: rtl/mio_sync.sv
module mio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] chain [STAGES];
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= pad_in;
      end
      // R8: first stage samples the pad one edge back
      p_sync_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> chain[0] == $past(pad_in));
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
      // R8: each stage adds exactly one edge
      p_sync_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> chain[g] == $past(chain[g-1]));
    end
  end

  assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/mio_pin.sv
module mio_pin (
  input  logic               data_b,
  input  logic               dir_b,
  input  logic               ien_b,
  input  logic               pin_b,
  output logic               pad_out_b,
  output logic               pad_oe_b,
  output logic               ana_b,
  output logic               rd_b,
  output mio_pkg::pin_mode_e mode_b
);
  import mio_pkg::*;

  always_comb begin
    mode_b    = pin_mode(dir_b, ien_b);
    pad_out_b = data_b;
    pad_oe_b  = (mode_b == PIN_OUTPUT);
    ana_b     = (mode_b == PIN_ANALOG);
    rd_b      = pin_read(mode_b, data_b, pin_b);
  end

endmodule

// File: rtl/mio_port.sv
module mio_port #(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  ana_sel
);
  import mio_pkg::*;

  logic [WIDTH-1:0] data_q, dir_q, ien_q;
  logic             wr_data, wr_dir, wr_ien, wr_unmapped;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] pin_rd;
  logic [WIDTH-1:0] in_mask;
  pin_mode_e        mode_w [WIDTH];
  logic             rd_sel_data, rd_unmapped;

  mio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q), .ien_q(ien_q),
    .wr_data(wr_data), .wr_dir(wr_dir), .wr_ien(wr_ien),
    .wr_unmapped(wr_unmapped)
  );

  mio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_sync(pin_sync)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    mio_pin u_pin (
      .data_b(data_q[b]), .dir_b(dir_q[b]), .ien_b(ien_q[b]),
      .pin_b(pin_sync[b]), .pad_out_b(pad_out[b]), .pad_oe_b(pad_oe[b]),
      .ana_b(ana_sel[b]), .rd_b(pin_rd[b]), .mode_b(mode_w[b])
    );
    assign in_mask[b] = (mode_w[b] == PIN_INPUT);
  end

  always_comb begin
    rd_sel_data = (bus_addr == ADDR_W'(OFS_DATA));
    rd_unmapped = 1'b0;
    bus_rdata   = '0;
    if (rd_sel_data)                          bus_rdata = pin_rd;
    else if (bus_addr == ADDR_W'(OFS_DIR))    bus_rdata = dir_q;
    else if (bus_addr == ADDR_W'(OFS_IEN))    bus_rdata = ien_q;
    else                                      rd_unmapped = 1'b1;
  end

  // R2: output enable follows a direction write at the next edge
  p_oe_after_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pad_oe == $past(bus_wdata));
  // R2: enabled pads carry the latch
  p_pad_out_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ data_q) & pad_oe) == '0);
  // R3: output pins read the latch
  p_output_read_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_data |-> ((bus_rdata ^ data_q) & dir_q) == '0);
  // R4: input pins read the synchronized pad
  p_input_read_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_data |-> ((bus_rdata ^ pin_sync) & in_mask) == '0);
  // R5: analog pins read zero
  p_analog_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_data |-> (bus_rdata & ana_sel) == '0);
  // R10: analog and output never coincide
  p_analog_excl_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ana_sel) == '0);
  // R9: unmapped offset reads zero
  p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> bus_rdata == '0);

endmodule

// File: tb/mio_port_test.sv
module mio_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_out, pad_oe, ana_sel;
  logic [7:0] pad_in = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_in(pad_in), .ana_sel(ana_sel)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] d, input logic [7:0] i,
                                            input logic [7:0] l, input logic [7:0] p);
    return (d & l) | (~d & i & p);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ipat [4];
    ipat[0] = 8'h00; ipat[1] = 8'hFF; ipat[2] = 8'h5A; ipat[3] = 8'hC3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 ana_sel", ana_sel, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    rd(2'd0, v); check("R1 data read", v, 8'h00);
    rd(2'd1, v); check("R1 dir read", v, 8'h00);
    rd(2'd2, v); check("R1 ien read", v, 8'hFF);

    // R2 R3 R4 R5 R6 R10 sweep over all direction values
    for (int k = 0; k < 4; k++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] dv, iv, lv, pv;
        dv = 8'(d);
        iv = ipat[k];
        lv = ~dv ^ 8'h96 ^ 8'(k);
        pv = 8'(d * 29 + 7 + k);
        pad_in = pv;
        wr(2'd1, dv);
        wr(2'd2, iv);
        wr(2'd0, lv);
        check("R2 pad_oe", pad_oe, dv);
        check("R2 pad_out", pad_out, lv);
        check("R10 ana_sel", ana_sel, ~dv & ~iv);
        rd(2'd0, v); check("R3 R4 R5 data read", v, model_read(dv, iv, lv, pv));
        rd(2'd1, v); check("R6 dir read", v, dv);
        rd(2'd2, v); check("R6 ien read", v, iv);
      end
    end

    // R6 write takes effect at the next edge
    wr(2'd1, 8'h00);
    @(negedge clk);
    bus_addr = 2'd1; bus_we = 1'b1; bus_wdata = 8'hF0;
    #1;
    check("R6 before edge", pad_oe, 8'h00);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check("R6 after edge", pad_oe, 8'hF0);

    // R7 preload in analog mode
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check("R7 analog read", v, 8'h00);
    check("R7 pad_out preload", pad_out, 8'hA5);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); check("R7 output read", v, 8'hA5);
    check("R7 pad_oe", pad_oe, 8'hFF);

    // R8 two-edge synchronizer latency
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h3C;
    bus_addr = 2'd0;
    @(negedge clk);
    #1;
    check("R8 after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    #1;
    check("R8 after two edges", bus_rdata, 8'h3C);

    // R9 unmapped offset
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h56);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R9 unmapped read", v, 8'h00);
    rd(2'd1, v); check("R9 dir kept", v, 8'h34);
    rd(2'd2, v); check("R9 ien kept", v, 8'h56);
    check("R9 pad_out kept", pad_out, 8'h12);
    check("R9 pad_oe kept", pad_oe, 8'h34);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule